// File: doc/BRIEF.md
# Periodic Reload Timer with Compare

A 32-bit down-counting timer on a small word-addressed register bus. Software picks one of three tick-enable inputs as the count source and divides it with a 12-bit prescaler. The counter decrements once for each divided tick. When it reaches zero it either reloads from a software-written load value or wraps to all ones and runs free.

A compare register is watched while the timer runs. When the counter steps onto the compare value, a sticky flag is set. That flag, qualified by two control bits, drives a level interrupt.

Software can also do several things through the control register. It can restart the count from the load value each time the timer is enabled. It can push a new load value straight into the live counter. It can issue a software reset that clears most of the block while keeping the enable and low-power related control bits.

Top module: `reload_timer`

## Requirements
- R1: Registers are selected by the full byte address: 0x00 control, 0x04 status, 0x08 load, 0x0C compare, 0x10 counter. The counter is read-only. A write to any other address changes nothing, and a read from any other address returns 0.
- R2: Control bits 25:0 are writable and read back as written; bits 31:26 always read 0. Bit map: bit 0 enable, bit 1 restart-on-enable, bit 2 compare interrupt enable, bit 3 reload select, bits 15:4 prescale, bit 16 software reset, bit 17 immediate overwrite, bits 18 to 21 kept low-power/debug enables, bits 23:22 spare, bits 25:24 source.
- R3: The source field picks the tick input: 00 none (counter holds), 01 `tick_periph`, 10 `tick_fast`, 11 `tick_slow`.
- R4: The counter steps once every prescale+1 selected ticks. The prescaler phase restarts whenever the source or prescale field changes.
- R5: On a step from 0, the counter loads the load register when reload select is 1 and wraps to 0xFFFFFFFF when it is 0. Otherwise a step subtracts one.
- R6: On a 0-to-1 change of enable with restart-on-enable set, the counter is loaded with the load value if reload select is 1, else with 0xFFFFFFFF. With restart-on-enable clear, it resumes from its held value.
- R7: A load write with immediate overwrite set also writes the counter in the same cycle. With immediate overwrite clear, the counter keeps counting and the new value is used at the next reload.
- R8: The status flag (status bit 0) is set on a step that brings the counter onto the compare value, but only while enable and compare interrupt enable are both 1. If a match and a status clear occur in the same cycle, the flag stays set.
- R9: Writing status with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 has no effect.
- R10: `irq` is 1 exactly when the flag, compare interrupt enable and enable are all 1.
- R11: A control write with bit 16 set keeps bits 0, 1 and 18 to 21 of the written value and clears every other control bit. It also clears status and compare, sets load to 0xFFFFFFFF and sets the counter to 0xFFFFFFFF.
- R12: After hard reset: control 0, status 0, load 0xFFFFFFFF, compare 0, counter 0xFFFFFFFF, `irq` 0.
- R13: While enable is 0, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| tick_periph | input | 1 | Source 01 tick enable |
| tick_fast | input | 1 | Source 10 tick enable |
| tick_slow | input | 1 | Source 11 tick enable |
| irq | output | 1 | Level compare interrupt |

## Verification
The bench uses the default parameters: a 5-bit address and a 32-bit count. The all-ones wrap of free-running mode would take billions of ticks to reach by counting down, so the bench reaches it by writing a small value into the live counter with immediate overwrite. It then watches the step from 0 to 0xFFFFFFFF. Small load and compare values and a prescale of 3 keep reload, prescaler phase and the collision of a match with a status clear within a few dozen cycles. The bench schedules each of these to land on a known clock edge.

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int AW = 5,
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          tick_periph,
  input  logic          tick_fast,
  input  logic          tick_slow,
  output logic          irq
);
  localparam logic [TW-1:0] TOP  = '1;
  localparam logic [25:0]   KEEP = 26'h03C0003;

  logic [25:0]   ctrl;
  logic          flag;
  logic [TW-1:0] load_q, cmp_q, cnt;
  logic [11:0]   pcnt;

  wire en    = ctrl[0];
  wire ocien = ctrl[2];
  wire rld   = ctrl[3];
  wire iovw  = ctrl[17];
  wire [11:0] pre = ctrl[15:4];
  wire [1:0]  src = ctrl[25:24];

  wire wr_ctrl = bus_sel && bus_wr && bus_addr == AW'(5'h00);
  wire wr_stat = bus_sel && bus_wr && bus_addr == AW'(5'h04);
  wire wr_load = bus_sel && bus_wr && bus_addr == AW'(5'h08);
  wire wr_cmp  = bus_sel && bus_wr && bus_addr == AW'(5'h0C);

  wire [25:0] wnew  = bus_wdata[25:0];
  wire        swr   = wr_ctrl && wnew[16];
  wire [25:0] ctrl_d = swr ? (wnew & KEEP) : wnew;
  wire        rise  = wr_ctrl && !swr && wnew[0] && !en && wnew[1];

  logic src_tick;
  always_comb begin
    case (src)
      2'b01:   src_tick = tick_periph;
      2'b10:   src_tick = tick_fast;
      2'b11:   src_tick = tick_slow;
      default: src_tick = 1'b0;
    endcase
  end

  wire           step    = en && src_tick && pcnt == pre;
  wire [TW-1:0]  cnt_dec = (cnt == '0) ? (rld ? load_q : TOP) : cnt - 1'b1;
  wire           match   = step && ocien && cnt_dec == cmp_q;
  wire           pre_rst = wr_ctrl && (ctrl_d[25:24] != src || ctrl_d[15:4] != pre);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      flag   <= 1'b0;
      load_q <= TOP;
      cmp_q  <= '0;
      cnt    <= TOP;
      pcnt   <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_d;

      if (swr)                         load_q <= TOP;
      else if (wr_load)                load_q <= bus_wdata[TW-1:0];

      if (swr)                         cmp_q <= '0;
      else if (wr_cmp)                 cmp_q <= bus_wdata[TW-1:0];

      if (swr)                         flag <= 1'b0;
      else if (match)                  flag <= 1'b1;
      else if (wr_stat && bus_wdata[0]) flag <= 1'b0;

      if (swr)                         cnt <= TOP;
      else if (rise)                   cnt <= wnew[3] ? load_q : TOP;
      else if (wr_load && iovw)        cnt <= bus_wdata[TW-1:0];
      else if (step)                   cnt <= cnt_dec;

      if (pre_rst)                     pcnt <= '0;
      else if (en && src_tick)         pcnt <= (pcnt == pre) ? '0 : pcnt + 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      AW'(5'h00): bus_rdata = {6'b0, ctrl};
      AW'(5'h04): bus_rdata = {31'b0, flag};
      AW'(5'h08): bus_rdata = 32'(load_q);
      AW'(5'h0C): bus_rdata = 32'(cmp_q);
      AW'(5'h10): bus_rdata = 32'(cnt);
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = flag && ocien && en;
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [25:0]   ctrl,
  input logic          flag,
  input logic [TW-1:0] cnt,
  input logic [TW-1:0] load_q,
  input logic          step,
  input logic          wr_ctrl,
  input logic          wr_stat,
  input logic          wr_load,
  input logic [31:0]   bus_wdata
);
  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !wr_ctrl && !wr_load) |=> $stable(cnt));

  assert_no_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[25:24] == 2'b00 && !wr_ctrl && !wr_load) |=> $stable(cnt));

  assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != '0 && !wr_ctrl && !(wr_load && ctrl[17])) |=> cnt == $past(cnt) - 1'b1);

  assert_swr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[16]) |=> (!ctrl[16] && !flag && load_q == '1 && cnt == '1));

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && !step) |=> !flag);

  assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(ctrl[0] && ctrl[2]));
endmodule

bind reload_timer reload_timer_chk #(.TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .flag(flag), .cnt(cnt),
  .load_q(load_q), .step(step), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
  .wr_load(wr_load), .bus_wdata(bus_wdata)
);

// File: tb/reload_timer_tb.sv
module reload_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_periph = 1'b1, tick_fast = 1'b0, tick_slow = 1'b0;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  reload_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_periph(tick_periph), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R12 ctrl", 5'h00, 32'h0);
    rd_chk("R12 status", 5'h04, 32'h0);
    rd_chk("R12 load", 5'h08, 32'hFFFF_FFFF);
    rd_chk("R12 cmp", 5'h0C, 32'h0);
    rd_chk("R12 cnt", 5'h10, 32'hFFFF_FFFF);
    check("R12 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_map;
    wr(5'h14, 32'h1234_5678);
    rd_chk("R1 unmapped read", 5'h14, 32'h0);
    rd_chk("R1 unmapped read 0x18", 5'h18, 32'h0);
    rd_chk("R1 unmapped write ignored", 5'h08, 32'hFFFF_FFFF);
    wr(5'h00, 32'hFFFE_FFFE);
    rd_chk("R2 ctrl mask", 5'h00, 32'h03FE_FFFE);
    wr(5'h00, 32'h0);
    wr(5'h10, 32'h5);
    rd_chk("R1 counter read-only", 5'h10, 32'hFFFF_FFFF);
  endtask

  task automatic t_reload;
    wr(5'h08, 32'd5);
    wr(5'h00, 32'h0100_000B);
    rd_chk("R6 enable loads", 5'h10, 32'd5);
    wait_n(3);
    rd_chk("R5 countdown", 5'h10, 32'd2);
    wait_n(3);
    rd_chk("R5 reload at zero", 5'h10, 32'd5);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_free_iovw;
    wr(5'h00, 32'h0102_0003);
    rd_chk("R6 enable no reload", 5'h10, 32'hFFFF_FFFF);
    wr(5'h08, 32'd2);
    rd_chk("R7 overwrite", 5'h10, 32'd2);
    wait_n(2);
    rd_chk("R5 free reach zero", 5'h10, 32'd0);
    wait_n(1);
    rd_chk("R5 wrap to max", 5'h10, 32'hFFFF_FFFF);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_iovw_off;
    wr(5'h08, 32'd10);
    wr(5'h00, 32'h0100_000B);
    rd_chk("R6 enable loads 10", 5'h10, 32'd10);
    wr(5'h08, 32'd3);
    rd_chk("R7 no overwrite", 5'h10, 32'd9);
    wait_n(9);
    rd_chk("R7 reach zero", 5'h10, 32'd0);
    wait_n(1);
    rd_chk("R7 new load at reload", 5'h10, 32'd3);
  endtask

  task automatic t_resume;
    logic [31:0] h;
    wr(5'h00, 32'h0100_0008);
    bus_addr = 5'h10; #1; h = bus_rdata;
    wait_n(3);
    rd_chk("R13 hold while disabled", 5'h10, h);
    wr(5'h00, 32'h0100_0009);
    rd_chk("R6 resume held", 5'h10, h);
    wait_n(2);
    rd_chk("R6 resume counts", 5'h10, h - 32'd2);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_prescale;
    wr(5'h08, 32'd100);
    wr(5'h00, 32'h0100_003B);
    rd_chk("R4 start", 5'h10, 32'd100);
    wait_n(3);
    rd_chk("R4 no step before ratio", 5'h10, 32'd100);
    wait_n(1);
    rd_chk("R4 first step", 5'h10, 32'd99);
    wait_n(4);
    rd_chk("R4 second step", 5'h10, 32'd98);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_source;
    wr(5'h08, 32'd50);
    wr(5'h00, 32'h0200_000B);
    wait_n(3);
    rd_chk("R3 fast idle", 5'h10, 32'd50);
    tick_fast = 1'b1;
    wait_n(2);
    rd_chk("R3 fast selected", 5'h10, 32'd48);
    tick_fast = 1'b0;
    wr(5'h00, 32'h0);
    wr(5'h00, 32'h0300_000B);
    wait_n(2);
    rd_chk("R3 slow idle", 5'h10, 32'd50);
    tick_slow = 1'b1;
    wait_n(1);
    tick_slow = 1'b0;
    rd_chk("R3 slow selected", 5'h10, 32'd49);
    wr(5'h00, 32'h0);
    tick_fast = 1'b1; tick_slow = 1'b1;
    wr(5'h00, 32'h0000_000B);
    wait_n(3);
    rd_chk("R3 no source holds", 5'h10, 32'd50);
    tick_fast = 1'b0; tick_slow = 1'b0;
    wr(5'h00, 32'h0);
  endtask

  task automatic t_compare;
    wr(5'h04, 32'h1);
    wr(5'h0C, 32'd7);
    wr(5'h08, 32'd10);
    wr(5'h00, 32'h0100_000B);
    wait_n(3);
    rd_chk("R8 at cmp without ocien", 5'h10, 32'd7);
    rd_chk("R8 no flag without ocien", 5'h04, 32'h0);
    wr(5'h00, 32'h0);
    wr(5'h00, 32'h0100_000F);
    wait_n(3);
    rd_chk("R8 at cmp", 5'h10, 32'd7);
    rd_chk("R8 flag set", 5'h04, 32'h1);
    check("R10 irq high", {31'b0, irq}, 32'h1);
    wr(5'h04, 32'h0);
    rd_chk("R9 zero write no effect", 5'h04, 32'h1);
    wr(5'h04, 32'h1);
    rd_chk("R9 clear", 5'h04, 32'h0);
    check("R10 irq low after clear", {31'b0, irq}, 32'h0);
    wr(5'h00, 32'h0);
    wr(5'h00, 32'h0100_000F);
    wait_n(2);
    wr(5'h04, 32'h1);
    rd_chk("R8 match beats clear", 5'h04, 32'h1);
    wr(5'h00, 32'h0100_000C);
    check("R10 irq needs enable", {31'b0, irq}, 32'h0);
    rd_chk("R10 flag kept", 5'h04, 32'h1);
  endtask

  task automatic t_swr;
    wr(5'h00, 32'h0127_005F);
    rd_chk("R11 ctrl kept bits", 5'h00, 32'h0024_0003);
    rd_chk("R11 status", 5'h04, 32'h0);
    rd_chk("R11 load", 5'h08, 32'hFFFF_FFFF);
    rd_chk("R11 cmp", 5'h0C, 32'h0);
    rd_chk("R11 cnt", 5'h10, 32'hFFFF_FFFF);
    check("R11 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_reload();
    t_free_iovw();
    t_iovw_off();
    t_resume();
    t_prescale();
    t_source();
    t_compare();
    t_swr();
    finish_run();
  end
endmodule